// File: doc/BRIEF.md
# Interprocessor Mailbox Controller

This block lets several processors on one chip pass short, fixed-size messages to each other. It holds a set of mailboxes, each with an owner channel, a set of destination channels, a per-channel interrupt mask, a small mode field, a block of data words and a send register. A processor claims a mailbox by writing its own channel bit into the owner register. It then fills in the data words and the destinations, and writes the send register to post the message. The destinations are interrupted. The receiver reads the words and writes an acknowledge code into the same send register, which turns the interrupt around toward the owner. Writing zero to the send register returns the mailbox to idle.

Each processor channel has its own interrupt line. The line is the OR, over all mailboxes, of that channel's masked pending bits. Software reads these bits as one masked word and one raw word per channel, where bit m stands for mailbox m. The bus side is a plain single-cycle register port: a write happens on the clock edge when the write enable is high, and read data is a combinational function of the address and the register state. Control and status pins are plain levels with no back-pressure.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset every register reads zero, every send register reads 0 (idle) and all interrupt outputs are low.
- R2: Destination and mask registers hold one bit per channel. A one written to the set word (+0x04 destination, +0x14 mask) sets that bit, a one written to the clear word (+0x08, +0x18) clears it, and zeros leave bits unchanged. The current value reads back at +0x0C (destination) and +0x1C (mask).
- R3: The owner register at +0x00 takes the low channel-width bits of a write only when it currently holds zero or the written value is zero. Otherwise the write is dropped.
- R4: Seven 32-bit data words per mailbox sit at +0x24 to +0x3C, 4 bytes apart, and read back what was last accepted.
- R5: Writing 1 to the send register (+0x20, bits [1:0]) puts the mailbox in the sent state. The send register then reads 1, and the raw pending bit for this mailbox is set for every destination channel.
- R6: Writing 2 to the send register puts the mailbox in the acknowledged state. The send register then reads 2, and the raw pending bit is set only for the owner channel(s).
- R7: Writing 0 to the send register returns the mailbox to idle and clears all of its pending bits. Writing 3 leaves the state unchanged.
- R8: The channel c masked word at 0x800+8c equals its raw word at 0x804+8c ANDed with each mailbox's mask bit c, with bit m for mailbox m. Interrupt output c is high exactly when that masked word is non-zero.
- R9: While a mailbox is in the sent state, writes to its data words, destination set/clear, mask set/clear and mode register have no effect.
- R10: Unmapped reads return zero. This covers a mailbox index at or above the mailbox count, a status channel at or above the channel count, and the set/clear words.
- R11: The mode register at +0x10 stores the low 2 bits of a write and reads them back.
- R12: Mailboxes sit 0x40 bytes apart, so mailbox m's registers start at m×0x40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle while high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 8 | One interrupt line per channel |

## Verification
The assertions assume that every access is word aligned, so the two low address bits are always zero. They also assume that a write strobe lasts exactly one clock for each intended write. The stimulus drives aligned addresses only, including the unmapped ones. It pulses the write strobe for a single cycle per write. It picks owner values as zero or one-hot and send codes from the four two-bit values, while mode, data and mask writes carry arbitrary bits. Random traffic also aims at one mailbox index past the last one and one channel past the last one, so the decode boundaries stay within the exercised space.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SENT  = 2'd1,
    ST_ACKED = 2'd2
  } mbx_state_e;

  // word offsets inside one mailbox window (address bits [5:2])
  localparam logic [3:0] OFF_SRC   = 4'd0;
  localparam logic [3:0] OFF_DSET  = 4'd1;
  localparam logic [3:0] OFF_DCLR  = 4'd2;
  localparam logic [3:0] OFF_DSTAT = 4'd3;
  localparam logic [3:0] OFF_MODE  = 4'd4;
  localparam logic [3:0] OFF_MSET  = 4'd5;
  localparam logic [3:0] OFF_MCLR  = 4'd6;
  localparam logic [3:0] OFF_MSTAT = 4'd7;
  localparam logic [3:0] OFF_SEND  = 4'd8;
  localparam logic [3:0] OFF_DATA0 = 4'd9;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int N_CHAN  = 8,
  parameter int N_WORDS = 7,
  parameter int DATA_W  = 32,
  parameter int MODE_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [3:0]                     wr_off,
  input  logic [DATA_W-1:0]              wdata,
  output logic [N_CHAN-1:0]              src_q,
  output logic [N_CHAN-1:0]              dst_q,
  output logic [N_CHAN-1:0]              msk_q,
  output logic [MODE_W-1:0]              mode_q,
  output mbx_state_e                     state_q,
  output logic [N_WORDS-1:0][DATA_W-1:0] data_q,
  output logic [N_CHAN-1:0]              raw_o,
  output logic [N_CHAN-1:0]              masked_o
);
  logic              locked;
  logic [N_CHAN-1:0] wbits;

  assign locked = (state_q == ST_SENT);
  assign wbits  = wdata[N_CHAN-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      msk_q   <= '0;
      mode_q  <= '0;
      state_q <= ST_IDLE;
    end else if (wr_en) begin
      case (wr_off)
        OFF_SRC:  if (src_q == '0 || wbits == '0) src_q <= wbits;
        OFF_DSET: if (!locked) dst_q <= dst_q | wbits;
        OFF_DCLR: if (!locked) dst_q <= dst_q & ~wbits;
        OFF_MSET: if (!locked) msk_q <= msk_q | wbits;
        OFF_MCLR: if (!locked) msk_q <= msk_q & ~wbits;
        OFF_MODE: if (!locked) mode_q <= wdata[MODE_W-1:0];
        OFF_SEND: begin
          case (wdata[1:0])
            2'd0:    state_q <= ST_IDLE;
            2'd1:    state_q <= ST_SENT;
            2'd2:    state_q <= ST_ACKED;
            default: state_q <= state_q;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_en && !locked) begin
      for (int w = 0; w < N_WORDS; w++) begin
        if (wr_off == 4'(int'(OFF_DATA0) + w)) data_q[w] <= wdata;
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_SENT:  raw_o = dst_q;
      ST_ACKED: raw_o = src_q;
      default:  raw_o = '0;
    endcase
  end
  assign masked_o = raw_o & msk_q;

  // R3: a non-zero owner is only replaced through zero
  p_owner_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_SRC && src_q != '0 && wbits != '0) |=> $stable(src_q));

  // R9: destination set is locked while sent
  p_dest_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && wr_off == OFF_DSET) |=> $stable(dst_q));

  // R9: data words are locked while sent
  p_data_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && wr_off >= OFF_DATA0) |=> $stable(data_q));

  // R7: writing zero to send leaves nothing pending
  p_idle_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_SEND && wdata[1:0] == 2'd0) |=> (raw_o == '0));

  // R7: code 3 keeps the state
  p_code3_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_SEND && wdata[1:0] == 2'd3) |=> $stable(state_q));

  // R5: a send code of 1 leads to the sent state
  p_send_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_SEND && wdata[1:0] == 2'd1) |=> (state_q == ST_SENT));
endmodule

// File: rtl/mbx_irq_route.sv
module mbx_irq_route #(
  parameter int N_MBOX = 8,
  parameter int N_CHAN = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_MBOX-1:0][N_CHAN-1:0]  raw_mc,
  input  logic [N_MBOX-1:0][N_CHAN-1:0]  masked_mc,
  output logic [N_CHAN-1:0][N_MBOX-1:0]  raw_cm,
  output logic [N_CHAN-1:0][N_MBOX-1:0]  masked_cm,
  output logic [N_CHAN-1:0]              irq_o
);
  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    for (genvar m = 0; m < N_MBOX; m++) begin : g_mbox
      assign raw_cm[c][m]    = raw_mc[m][c];
      assign masked_cm[c][m] = masked_mc[m][c];
    end
    assign irq_o[c] = |masked_cm[c];

    // R8: an interrupt line needs a raw pending bit behind it
    p_irq_has_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> (raw_cm[c] != '0));
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int N_MBOX  = 8,
  parameter int N_CHAN  = 8,
  parameter int N_WORDS = 7,
  parameter int DATA_W  = 32,
  parameter int MODE_W  = 2,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_CHAN-1:0] irq_o
);
  localparam int MSEL_W = ADDR_W - 7;  // mailbox index, bits [ADDR_W-2:6]
  localparam int CSEL_W = ADDR_W - 4;  // status channel, bits [ADDR_W-2:3]

  logic [MSEL_W-1:0] mbx_sel;
  logic [CSEL_W-1:0] ch_sel;
  logic [3:0]        off;
  logic              in_mbx, in_stat;
  logic              unused_addr_lsb;

  assign mbx_sel         = reg_addr[ADDR_W-2:6];
  assign ch_sel          = reg_addr[ADDR_W-2:3];
  assign off             = reg_addr[5:2];
  assign in_mbx          = !reg_addr[ADDR_W-1] && (32'(mbx_sel) < N_MBOX);
  assign in_stat         = reg_addr[ADDR_W-1] && (32'(ch_sel) < N_CHAN);
  assign unused_addr_lsb = ^reg_addr[1:0];

  logic [N_CHAN-1:0]              slot_src   [N_MBOX];
  logic [N_CHAN-1:0]              slot_dst   [N_MBOX];
  logic [N_CHAN-1:0]              slot_msk   [N_MBOX];
  logic [MODE_W-1:0]              slot_mode  [N_MBOX];
  mbx_state_e                     slot_state [N_MBOX];
  logic [N_WORDS-1:0][DATA_W-1:0] slot_data  [N_MBOX];
  logic [N_MBOX-1:0][N_CHAN-1:0]  raw_mc, masked_mc;
  logic [N_CHAN-1:0][N_MBOX-1:0]  raw_cm, masked_cm;

  for (genvar i = 0; i < N_MBOX; i++) begin : g_slot
    logic slot_we;
    assign slot_we = reg_we && in_mbx && (32'(mbx_sel) == i);

    mbx_slot #(
      .N_CHAN (N_CHAN),
      .N_WORDS(N_WORDS),
      .DATA_W (DATA_W),
      .MODE_W (MODE_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (slot_we),
      .wr_off  (off),
      .wdata   (reg_wdata),
      .src_q   (slot_src[i]),
      .dst_q   (slot_dst[i]),
      .msk_q   (slot_msk[i]),
      .mode_q  (slot_mode[i]),
      .state_q (slot_state[i]),
      .data_q  (slot_data[i]),
      .raw_o   (raw_mc[i]),
      .masked_o(masked_mc[i])
    );
  end

  mbx_irq_route #(
    .N_MBOX(N_MBOX),
    .N_CHAN(N_CHAN)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_mc   (raw_mc),
    .masked_mc(masked_mc),
    .raw_cm   (raw_cm),
    .masked_cm(masked_cm),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (in_mbx) begin
      for (int i = 0; i < N_MBOX; i++) begin
        if (32'(mbx_sel) == i) begin
          case (off)
            OFF_SRC:   reg_rdata[N_CHAN-1:0] = slot_src[i];
            OFF_DSTAT: reg_rdata[N_CHAN-1:0] = slot_dst[i];
            OFF_MSTAT: reg_rdata[N_CHAN-1:0] = slot_msk[i];
            OFF_MODE:  reg_rdata[MODE_W-1:0] = slot_mode[i];
            OFF_SEND:  reg_rdata[1:0]        = slot_state[i];
            default: begin
              for (int w = 0; w < N_WORDS; w++) begin
                if (off == 4'(int'(OFF_DATA0) + w)) reg_rdata = slot_data[i][w];
              end
            end
          endcase
        end
      end
    end else if (in_stat) begin
      for (int c = 0; c < N_CHAN; c++) begin
        if (32'(ch_sel) == c)
          reg_rdata[N_MBOX-1:0] = reg_addr[2] ? raw_cm[c] : masked_cm[c];
      end
    end
  end

  // R10: an address past the last status channel reads zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1] && !in_stat) |-> (reg_rdata == '0));

  // R1: interrupts are quiet on the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_o == '0));
endmodule

// File: tb/mbx_ctrl_tb.sv
module mbx_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mbx_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_o    (irq_o)
  );

  // bench model of the programmer-visible state
  logic [7:0]  m_src [8];
  logic [7:0]  m_dst [8];
  logic [7:0]  m_msk [8];
  logic [1:0]  m_mode[8];
  logic [1:0]  m_st  [8];
  logic [31:0] m_dat [8][7];

  function automatic logic raw_bit(int m, int c);
    return (m_st[m] == 2'd1 && m_dst[m][c]) || (m_st[m] == 2'd2 && m_src[m][c]);
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    logic [31:0] r = '0;
    int mb = int'(a[10:6]);
    int ch = int'(a[10:3]);
    int of = int'(a[5:2]);
    if (a[11]) begin
      if (ch < 8)
        for (int m = 0; m < 8; m++) r[m] = raw_bit(m, ch) && (a[2] || m_msk[m][ch]);
    end else if (mb < 8) begin
      case (of)
        0: r[7:0] = m_src[mb];
        3: r[7:0] = m_dst[mb];
        4: r[1:0] = m_mode[mb];
        7: r[7:0] = m_msk[mb];
        8: r[1:0] = m_st[mb];
        default: if (of >= 9) r = m_dat[mb][of-9];
      endcase
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_irq();
    logic [7:0] r = '0;
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 8; m++) if (raw_bit(m, c) && m_msk[m][c]) r[c] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] v);
    int mb = int'(a[10:6]);
    int of = int'(a[5:2]);
    logic lk;
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_we = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
    if (!a[11] && mb < 8) begin
      lk = (m_st[mb] == 2'd1);
      case (of)
        0: if (m_src[mb] == 0 || v[7:0] == 0) m_src[mb] = v[7:0];
        1: if (!lk) m_dst[mb] = m_dst[mb] | v[7:0];
        2: if (!lk) m_dst[mb] = m_dst[mb] & ~v[7:0];
        4: if (!lk) m_mode[mb] = v[1:0];
        5: if (!lk) m_msk[mb] = m_msk[mb] | v[7:0];
        6: if (!lk) m_msk[mb] = m_msk[mb] & ~v[7:0];
        8: if (v[1:0] != 2'd3) m_st[mb] = v[1:0];
        default: if (of >= 9 && !lk) m_dat[mb][of-9] = v;
      endcase
    end
  endtask

  task automatic rd(string tag, logic [11:0] a);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    #1 chk(tag, reg_rdata, exp_rd(a));
  endtask

  task automatic chk_irq(string tag);
    #1 chk(tag, {24'd0, irq_o}, {24'd0, exp_irq()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    for (int m = 0; m < 8; m++) begin
      m_src[m] = '0; m_dst[m] = '0; m_msk[m] = '0; m_mode[m] = '0; m_st[m] = '0;
      for (int w = 0; w < 7; w++) m_dat[m][w] = '0;
    end
    reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; rst_n = 1'b0;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd("R1", 12'h000); rd("R1", 12'h1FC); rd("R1", 12'h1E0);
    rd("R1", 12'h800); rd("R1", 12'h83C); chk_irq("R1");

    // mailbox 1 handshake (R12: base 0x40)
    wr(12'h040, 32'h02);        rd("R12", 12'h040);
    wr(12'h040, 32'h04);        rd("R3", 12'h040);
    wr(12'h044, 32'h01);        rd("R2", 12'h04C);
    wr(12'h054, 32'h03);        rd("R2", 12'h05C);
    wr(12'h050, 32'hFFFF_FFFF); rd("R11", 12'h050);
    for (int w = 0; w < 7; w++) wr(12'(12'h064 + 4*w), 32'hA5A5_0000 + w);
    rd("R4", 12'h064); rd("R4", 12'h07C);
    wr(12'h060, 32'h1);         rd("R5", 12'h060); rd("R5", 12'h804);
    chk_irq("R8");              rd("R8", 12'h800);
    wr(12'h064, 32'hDEAD_BEEF); rd("R9", 12'h064);
    wr(12'h048, 32'h01);        rd("R9", 12'h04C);
    wr(12'h058, 32'h01);        rd("R9", 12'h05C);
    wr(12'h050, 32'h0);         rd("R9", 12'h050);
    wr(12'h060, 32'h3);         rd("R7", 12'h060);
    wr(12'h060, 32'h2);         rd("R6", 12'h060); rd("R6", 12'h80C);
    rd("R6", 12'h804);          chk_irq("R6");
    wr(12'h058, 32'h02);        chk_irq("R8"); rd("R8", 12'h80C); rd("R8", 12'h808);
    wr(12'h060, 32'h0);         rd("R7", 12'h80C); chk_irq("R7");
    wr(12'h048, 32'h01);        rd("R2", 12'h04C);
    wr(12'h040, 32'h0);         wr(12'h040, 32'h08); rd("R3", 12'h040);
    rd("R10", 12'h200); rd("R10", 12'h840); rd("R10", 12'h044); rd("R10", 12'h7FC);

    // constrained random traffic
    for (int it = 0; it < 4000; it++) begin
      int mb = int'($urandom_range(0, 8));
      int of = int'($urandom_range(0, 15));
      logic [31:0] v;
      logic [11:0] a = 12'(mb * 64 + of * 4);
      if (of == 0)      v = ($urandom_range(0, 2) == 0) ? 32'd0 : 32'(1 << $urandom_range(0, 7));
      else if (of == 8) v = 32'($urandom_range(0, 3));
      else              v = $urandom;
      if ($urandom_range(0, 1) == 1) wr(a, v);
      else rd("R4", a);
      if (it % 4 == 0)
        rd("R8", 12'(12'h800 + 8 * $urandom_range(0, 8) + 4 * $urandom_range(0, 1)));
      chk_irq("R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule